// File: doc/BRIEF.md
# Daisy-Chained Bus Arbiter

This block hands a shared bus to one of `N_DEV` devices at a time. Every device drives its own active-low request pin. The pins are combined into one shared request line that reads low when any device pulls it down. The line is modelled as the AND of the per-device pins. A central controller raises a single root grant. That grant ripples through a chain of stages, one per device, starting at device 0. A stage whose device is requesting keeps the grant. A stage whose device is idle forwards the grant to the next stage.

The device that captures the grant owns the bus until it pulses its `done` pin. All `done` pins are combined into one shared release line. After a release, the controller spends one gap cycle with every grant low. It then returns to idle and arbitrates again from the requests present at that time. Priority is fixed by position in the chain, so device 0 can starve higher-numbered devices indefinitely. The captured owner is registered and presented as an index next to the one-hot grant vector.

Top module: `daisy_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `grant` is all zeros, `bus_busy` is 0 and `owner_idx` is 0.
- R2: Request pins are active low: bit i of `req_n` at 0 means device i requests. With every bit at 1, no grant is ever issued and `bus_busy` stays 0.
- R3: At most one bit of `grant` is 1 in any cycle. Bit i of `grant` gives the bus to device i.
- R4: When arbitration happens, the requesting device with the lowest index wins. `owner_idx` then holds that index in binary.
- R5: If the controller is idle and the shared request line is low at a clock edge, then after that edge the winner's `grant` bit and `bus_busy` are both 1.
- R6: While a device holds the grant and the release line stays low, its grant is unchanged. This holds when its own request pin goes high, and it holds when other devices request.
- R7: When any `done` bit is 1 at an edge during ownership, `grant` is all zeros after that edge and after the next edge. A new grant can appear only after the edge that follows those two.
- R8: A device that requests continuously from device 0 wins every arbitration over device `N_DEV-1`, which is never granted while that continues.
- R9: `bus_busy` is 1 exactly in the cycles in which some `grant` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | N_DEV | Per-device active-low request pins, wired onto the shared request line |
| done | input | N_DEV | Per-device release pulses, ORed onto the shared release line |
| grant | output | N_DEV | One-hot grant, bit i for device i |
| owner_idx | output | IDX_W | Registered index of the current or last owner |
| bus_busy | output | 1 | 1 while the bus is owned |

## Verification
The assertions assume that only the current owner drives `done`, and only while it holds the grant. The release line is shared, so a stray `done` from another device would end the ownership and break the hold property. The stimulus raises `done` only for the device that the bench expects to own the bus, and only for one cycle. The priority property compares the registered owner with the lowest active request pin sampled at the arbitration edge. To keep that comparison valid, the bench changes `req_n` only between clock edges.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GAP  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/arb_chain_stage.sv
module arb_chain_stage (
  input  logic grant_in,
  input  logic dev_req_n,
  output logic take,
  output logic grant_out
);
  // keep the grant when the local device requests, else forward it
  assign take      = grant_in & ~dev_req_n;
  assign grant_out = grant_in &  dev_req_n;
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
  parameter int N_DEV = 4,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_req,
  input  logic             line_rel,
  input  logic [N_DEV-1:0] take,
  output logic             root_grant,
  output logic [N_DEV-1:0] grant,
  output logic [IDX_W-1:0] owner_idx,
  output logic             bus_busy
);
  import arb_pkg::*;

  arb_state_t       state_q, state_d;
  logic [N_DEV-1:0] owner_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] take_idx;

  assign root_grant = (state_q == ST_IDLE) & line_req;

  always_comb begin
    take_idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (take[i]) take_idx = IDX_W'(i);
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (root_grant) state_d = ST_HOLD;
      ST_HOLD: if (line_rel)   state_d = ST_GAP;
      ST_GAP:                  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (root_grant) begin
        owner_q <= take;
        idx_q   <= take_idx;
      end
    end
  end

  assign bus_busy  = (state_q == ST_HOLD);
  assign grant     = bus_busy ? owner_q : '0;
  assign owner_idx = idx_q;
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int N_DEV = 4,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] req_n,
  input  logic [N_DEV-1:0] done,
  output logic [N_DEV-1:0] grant,
  output logic [IDX_W-1:0] owner_idx,
  output logic             bus_busy
);
  logic             line_req_n;
  logic             line_rel;
  logic             root_grant;
  logic [N_DEV:0]   chain;
  logic [N_DEV-1:0] take;

  // wired line: low when any device pulls it low
  assign line_req_n = &req_n;
  assign line_rel   = |done;
  assign chain[0]   = root_grant;

  for (genvar g = 0; g < N_DEV; g++) begin : g_stage
    arb_chain_stage u_stage (
      .grant_in  (chain[g]),
      .dev_req_n (req_n[g]),
      .take      (take[g]),
      .grant_out (chain[g+1])
    );
  end

  arb_grant_ctrl #(.N_DEV(N_DEV)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_req   (~line_req_n),
    .line_rel   (line_rel),
    .take       (take),
    .root_grant (root_grant),
    .grant      (grant),
    .owner_idx  (owner_idx),
    .bus_busy   (bus_busy)
  );
endmodule

// File: rtl/daisy_arbiter_chk.sv
module daisy_arbiter_chk #(
  parameter int N_DEV = 4,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] req_n,
  input logic [N_DEV-1:0] done,
  input logic [N_DEV-1:0] grant,
  input logic [IDX_W-1:0] owner_idx,
  input logic             bus_busy
);
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (!req_n[i]) low_idx = IDX_W'(i);
    end
  end

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_busy_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy == (grant != '0));

  p_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n && !bus_busy) |=> !bus_busy);

  p_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> (owner_idx == $past(low_idx)) && grant[owner_idx]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && done == '0) |=> bus_busy && $stable(grant));

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && done != '0) |=> (grant == '0) ##1 (grant == '0));
endmodule

bind daisy_arbiter daisy_arbiter_chk #(.N_DEV(N_DEV)) u_chk (.*);

// File: tb/daisy_arbiter_tb.sv
`timescale 1ns/1ps
module daisy_arbiter_tb;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_n = '1;
  logic [N-1:0]  done = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner_idx;
  logic          bus_busy;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  daisy_arbiter #(.N_DEV(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .done(done),
    .grant(grant), .owner_idx(owner_idx), .bus_busy(bus_busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_grant(input string tag, input logic [N-1:0] exp);
    chk(grant === exp, tag, int'(grant), int'(exp));
    chk(bus_busy === (exp != '0), {tag, " R9 busy"}, int'(bus_busy), int'(exp != '0));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // release by the owner; grant must be low for two edges (R7)
  task automatic release_owner(input int idx);
    done[idx] = 1'b1;
    tick();
    done = '0;
    chk_grant("R7 gap first", '0);
    tick();
    chk_grant("R7 gap second", '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk_grant("R1 in reset", '0);
    chk(owner_idx === 0, "R1 owner", int'(owner_idx), 0);
    rst_n = 1'b1;
    tick();
    chk_grant("R1 after reset", '0);
  endtask

  task automatic t_no_req();
    req_n = '1;
    repeat (5) tick();
    chk_grant("R2 no request", '0);
  endtask

  task automatic t_single();
    req_n = 4'b1011;
    tick();
    chk_grant("R5 single", 4'b0100);
    chk(owner_idx === 2, "R5 owner", int'(owner_idx), 2);
    req_n = '1;
    release_owner(2);
    tick();
    chk_grant("R2 idle after release", '0);
  endtask

  task automatic t_prio_hold();
    req_n = 4'b0010;
    tick();
    chk_grant("R4 prio", 4'b0001);
    chk(owner_idx === 0, "R4 owner", int'(owner_idx), 0);
    chk($countones(grant) <= 1, "R3 onehot", $countones(grant), 1);
    req_n = 4'b0011;
    repeat (3) tick();
    chk_grant("R6 hold", 4'b0001);
    release_owner(0);
    tick();
    chk_grant("R7 regrant", 4'b0100);
    chk(owner_idx === 2, "R4 next owner", int'(owner_idx), 2);
    req_n = '1;
    release_owner(2);
    tick();
  endtask

  task automatic t_starve();
    req_n = 4'b0110;
    for (int r = 0; r < 3; r++) begin
      tick();
      chk_grant("R8 near wins", 4'b0001);
      chk(grant[3] === 1'b0, "R8 far starved", int'(grant[3]), 0);
      release_owner(0);
    end
    req_n = 4'b0111;
    tick();
    chk_grant("R8 far after near drops", 4'b1000);
    chk(owner_idx === 3, "R8 owner", int'(owner_idx), 3);
    req_n = '1;
    release_owner(3);
    tick();
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_no_req();
    t_single();
    t_prio_hold();
    t_starve();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule